// File: doc/BRIEF.md
# Byte-Lane Access Splitter

This block connects a processor-side request port to a parallel data bus that is several bytes wide and has one active-high enable per byte lane. A request gives a byte address, an access width in bytes, a read or write flag, an address-space select (I/O or memory) and right-justified write data. The block turns each request into one or two bus cycles. Every cycle carries a word-aligned address, the byte enables of the lanes it covers, a command code and data placed on the matching lanes.

An access that stays inside one bus word goes out as a single cycle, even when it is misaligned. An access that runs past the end of a word becomes two cycles: first the lower word, then the next word up. For reads, the lanes returned by the two cycles are joined and shifted down, so the requested value sits at bit 0 of the response. A width that is not a power of two, or that is larger than the bus, gets an error response and produces no bus cycle. The request, bus and response sides all use valid/ready handshakes, and only one access is in flight at a time.

Top module: `lane_splitter`

## Requirements
- R1: After reset, req_ready is 1 and bus_valid and rsp_valid are 0.
- R2: In each bus cycle, bus_be[i] is 1 exactly when byte lane i holds a byte of the access. Byte k of the access (address addr+k) sits on lane (addr+k) mod 4, in the word at (addr+k) with the two low bits cleared.
- R3: An access whose bytes all lie in one 32-bit word is issued as exactly one cycle, with bus_addr set to that word's address. For example, 2 bytes at offset 1 give bus_be = 4'b0110.
- R4: An access that crosses a word boundary is issued as two cycles in order: first the lower word address, then that address plus 4. For example, 2 bytes at offset 3 give bus_be = 4'b1000 and then 4'b0001.
- R5: A 4-byte access at offset 1, 2 or 3 splits. Its first cycle enables lanes offset through 3, and its second cycle enables lanes 0 through offset-1.
- R6: bus_cmd = {is_io, is_write}: 2'b00 memory read, 2'b01 memory write, 2'b10 I/O read, 2'b11 I/O write. The enables and the split do not depend on the space select.
- R7: On writes, byte k of req_wdata appears on the lane given by R2, in the cycle that covers that lane. Lanes that are not enabled carry zero, and bytes of req_wdata at or above the access width are dropped.
- R8: A read response holds byte k of the access at rsp_rdata bits 8k+7:8k, with the bytes above the width set to zero. A write response returns rsp_rdata = 0.
- R9: While bus_valid is 1 and bus_ready is 0, bus_valid, bus_addr, bus_be, bus_cmd and bus_wdata hold their values into the next cycle.
- R10: req_ready goes to 0 in the cycle after a request is accepted and stays 0 until the response has been accepted.
- R11: req_size must be 1, 2 or 4. Any other value gives a response with rsp_err = 1 and rsp_rdata = 0 and no bus cycle. Valid requests respond with rsp_err = 0.
- R12: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_rdata and rsp_err hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW | Byte address |
| req_size | input | 3 | Access width in bytes (1, 2 or 4 valid) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 32 | Right-justified write value |
| bus_valid | output | 1 | Bus cycle present |
| bus_ready | input | 1 | Bus accepts cycle; read data is sampled with it |
| bus_addr | output | AW | Word-aligned cycle address |
| bus_cmd | output | 2 | Command code {is_io, is_write} |
| bus_be | output | 4 | Active-high byte enables |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_rdata | input | 32 | Lane-placed read data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Right-justified read value |
| rsp_err | output | 1 | Unsupported width |

## Verification
The assertions assume the bus acts on a cycle only when bus_valid and bus_ready are both high. They also assume that bus_ready and rsp_ready may drop at any cycle but come back within a bounded time, and that request fields matter only in the cycle of acceptance. The stimulus changes every input half a cycle away from the sampling edge. It drives both ready inputs from a pseudo-random pattern, so stalls of several cycles occur, and it fills disabled read lanes with live data rather than zero. Every width is tried at every offset, for both directions and both spaces, and the unsupported widths are mixed in between the valid ones.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_RESP   = 2'd3
    } lsp_state_e;
endpackage

// File: rtl/lsp_lane_plan.sv
// Works out lane coverage, enables, placed write data and the split decision
// from the low address bits and the width of the access.
module lsp_lane_plan #(
    parameter int NB = 4,
    parameter int SW = $clog2(NB) + 1,
    localparam int OW = $clog2(NB),
    localparam int DW = 8 * NB
) (
    input  logic [OW-1:0] off,
    input  logic [SW-1:0] size,
    input  logic [DW-1:0] wdata,
    output logic          size_ok,
    output logic          split,
    output logic [NB-1:0] be_lo,
    output logic [NB-1:0] be_hi,
    output logic [DW-1:0] wd_lo,
    output logic [DW-1:0] wd_hi,
    output logic [DW-1:0] val_mask
);
    logic [NB-1:0]   lanes;
    logic [2*NB-1:0] span;
    logic [2*DW-1:0] wide;

    always_comb begin
        size_ok = (size != '0) && ((size & (size - SW'(1))) == '0) && (size <= SW'(NB));
        for (int i = 0; i < NB; i++) begin
            lanes[i]          = SW'(i) < size;
            val_mask[8*i +: 8] = {8{lanes[i]}};
        end
        span  = {{NB{1'b0}}, lanes} << off;
        wide  = {{DW{1'b0}}, wdata & val_mask} << {off, 3'b000};
        be_lo = span[NB-1:0];
        be_hi = span[2*NB-1:NB];
        wd_lo = wide[DW-1:0];
        wd_hi = wide[2*DW-1:DW];
        split = size_ok && (be_hi != '0);
    end
endmodule

// File: rtl/lsp_read_merge.sv
// Joins the lanes of the two cycle words and right-justifies the value.
module lsp_read_merge #(
    parameter int NB = 4,
    localparam int OW = $clog2(NB),
    localparam int DW = 8 * NB
) (
    input  logic [OW-1:0] off,
    input  logic [DW-1:0] lo_word,
    input  logic [DW-1:0] hi_word,
    input  logic [DW-1:0] val_mask,
    output logic [DW-1:0] result
);
    logic [2*DW-1:0] joined;

    always_comb begin
        joined = {hi_word, lo_word} >> {off, 3'b000};
        result = joined[DW-1:0] & val_mask;
    end
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter #(
    parameter int AW = 32,
    parameter int NB = 4,
    localparam int SW = $clog2(NB) + 1,
    localparam int OW = $clog2(NB),
    localparam int DW = 8 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_size,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [DW-1:0] req_wdata,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_cmd,
    output logic [NB-1:0] bus_be,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err
);
    import lsp_pkg::*;

    typedef struct packed {
        lsp_state_e    st;
        logic [AW-1:0] waddr;
        logic [OW-1:0] off;
        logic [NB-1:0] be_lo;
        logic [NB-1:0] be_hi;
        logic [DW-1:0] wd_lo;
        logic [DW-1:0] wd_hi;
        logic [DW-1:0] mask;
        logic [DW-1:0] rd_lo;
        logic [DW-1:0] rdata;
        logic          split;
        logic          err;
        logic [1:0]    cmd;
    } regs_t;

    regs_t d, q;

    logic          plan_ok, plan_split;
    logic [NB-1:0] plan_be_lo, plan_be_hi;
    logic [DW-1:0] plan_wd_lo, plan_wd_hi, plan_mask;
    logic [DW-1:0] merge_lo, merge_hi, merged;

    lsp_lane_plan #(.NB(NB), .SW(SW)) u_plan (
        .off      (req_addr[OW-1:0]),
        .size     (req_size),
        .wdata    (req_wdata),
        .size_ok  (plan_ok),
        .split    (plan_split),
        .be_lo    (plan_be_lo),
        .be_hi    (plan_be_hi),
        .wd_lo    (plan_wd_lo),
        .wd_hi    (plan_wd_hi),
        .val_mask (plan_mask)
    );

    always_comb begin
        merge_lo = q.split ? q.rd_lo : bus_rdata;
        merge_hi = q.split ? bus_rdata : '0;
    end

    lsp_read_merge #(.NB(NB)) u_merge (
        .off      (q.off),
        .lo_word  (merge_lo),
        .hi_word  (merge_hi),
        .val_mask (q.mask),
        .result   (merged)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.waddr = {req_addr[AW-1:OW], {OW{1'b0}}};
                    d.off   = req_addr[OW-1:0];
                    d.be_lo = plan_be_lo;
                    d.be_hi = plan_be_hi;
                    d.wd_lo = plan_wd_lo;
                    d.wd_hi = plan_wd_hi;
                    d.mask  = plan_mask;
                    d.split = plan_split;
                    d.cmd   = {req_io, req_write};
                    d.err   = !plan_ok;
                    d.rd_lo = '0;
                    d.rdata = '0;
                    d.st    = plan_ok ? ST_FIRST : ST_RESP;
                end
            end
            ST_FIRST: begin
                if (bus_ready) begin
                    if (q.split) begin
                        d.rd_lo = bus_rdata;
                        d.st    = ST_SECOND;
                    end else begin
                        d.rdata = q.cmd[0] ? '0 : merged;
                        d.st    = ST_RESP;
                    end
                end
            end
            ST_SECOND: begin
                if (bus_ready) begin
                    d.rdata = q.cmd[0] ? '0 : merged;
                    d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        req_ready = (q.st == ST_IDLE);
        bus_valid = (q.st == ST_FIRST) || (q.st == ST_SECOND);
        bus_addr  = (q.st == ST_SECOND) ? q.waddr + AW'(NB) : q.waddr;
        bus_be    = (q.st == ST_SECOND) ? q.be_hi : q.be_lo;
        bus_wdata = (q.st == ST_SECOND) ? q.wd_hi : q.wd_lo;
        bus_cmd   = q.cmd;
        rsp_valid = (q.st == ST_RESP);
        rsp_rdata = q.rdata;
        rsp_err   = q.err;
    end

    // R9: a stalled bus cycle keeps every field
    p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
            && $stable(bus_cmd) && $stable(bus_wdata));

    // R10: acceptance closes the request port
    p_one_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R12: a stalled response keeps its value
    p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

    // R2: every issued cycle enables at least one lane
    p_be_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_be != '0);

    // R4: a cycle that leaves the top lane free is the last one of its access
    p_last_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready && !bus_be[NB-1] |=> !bus_valid);

    // R4: a cycle that directly follows an acknowledged one starts at lane 0
    p_second_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && $past(bus_valid && bus_ready) |-> bus_be[0]);
endmodule

// File: tb/lane_splitter_bench.sv
module lane_splitter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [1:0]  bus_cmd;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        logic [1:0]  cmd;
        logic [31:0] wd;
        string       tag;
    } exp_cyc_t;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
    } exp_rsp_t;

    exp_cyc_t cyc_q[$];
    exp_rsp_t rsp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_splitter u_lane_splitter (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size, .req_write,
        .req_io, .req_wdata, .bus_valid, .bus_ready, .bus_addr, .bus_cmd, .bus_be,
        .bus_wdata, .bus_rdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'hA5;
    endfunction

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: builds expected items from the requirements, then issues the request
    task automatic do_req(input logic [31:0] addr, input int n, input logic wr,
                          input logic io, input logic [31:0] wdata);
        logic [31:0] w0;
        logic [3:0]  be0, be1;
        logic [31:0] d0, d1, rd;
        logic        ok;
        string       t0;
        ok  = (n == 1) || (n == 2) || (n == 4);
        w0  = addr & ~32'd3;
        be0 = '0; be1 = '0; d0 = '0; d1 = '0; rd = '0;
        if (ok) begin
            for (int k = 0; k < n; k++) begin
                logic [31:0] a;
                int          ln;
                a  = addr + 32'(k);
                ln = int'(a[1:0]);
                if ((a & ~32'd3) == w0) begin
                    be0[ln] = 1'b1;
                    d0[8*ln +: 8] = wdata[8*k +: 8];
                end else begin
                    be1[ln] = 1'b1;
                    d1[8*ln +: 8] = wdata[8*k +: 8];
                end
                if (!wr) rd[8*k +: 8] = mem_byte(a);
            end
            t0 = (be1 != 0) ? ((n == 4) ? "R5 first" : "R4 first") : "R3 single";
            cyc_q.push_back('{w0, be0, {io, wr}, wr ? d0 : 32'h0, t0});
            if (be1 != 0)
                cyc_q.push_back('{w0 + 32'd4, be1, {io, wr}, wr ? d1 : 32'h0,
                                  (n == 4) ? "R5 second" : "R4 second"});
        end
        rsp_q.push_back('{rd, !ok});

        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = 3'(n);
        req_write = wr; req_io = io; req_wdata = wdata;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low after accept", {31'h0, req_ready}, 32'h0);
        while (!req_ready) @(negedge clk);
    endtask

    // Bus model and cycle monitor
    logic [7:0]  bus_lfsr = 8'h5B;
    logic        bus_stall = 1'b0;
    logic [31:0] hold_addr, hold_wd;
    logic [3:0]  hold_be;
    logic [1:0]  hold_cmd;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_stall) begin
                chk("R9 valid held", {31'h0, bus_valid}, 32'h1);
                chk("R9 addr held", bus_addr, hold_addr);
                chk("R9 be held", {28'h0, bus_be}, {28'h0, hold_be});
                chk("R9 data held", bus_wdata, hold_wd);
                chk("R9 cmd held", {30'h0, bus_cmd}, {30'h0, hold_cmd});
            end
            bus_lfsr  = {bus_lfsr[6:0], bus_lfsr[7] ^ bus_lfsr[5] ^ bus_lfsr[4] ^ bus_lfsr[3]};
            bus_ready = bus_lfsr[0] | bus_lfsr[2];
            for (int i = 0; i < 4; i++) bus_rdata[8*i +: 8] = mem_byte(bus_addr + 32'(i));
            if (bus_valid && bus_ready) begin
                if (cyc_q.size() == 0) begin
                    chk("R11 unexpected bus cycle", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    exp_cyc_t e;
                    e = cyc_q.pop_front();
                    chk({e.tag, " addr"}, bus_addr, e.addr);
                    chk({e.tag, " R2 be"}, {28'h0, bus_be}, {28'h0, e.be});
                    chk({e.tag, " R6 cmd"}, {30'h0, bus_cmd}, {30'h0, e.cmd});
                    if (e.cmd[0]) chk({e.tag, " R7 wdata"}, bus_wdata, e.wd);
                end
            end
            bus_stall = bus_valid && !bus_ready;
            hold_addr = bus_addr; hold_wd = bus_wdata; hold_be = bus_be; hold_cmd = bus_cmd;
        end
    end

    // Response monitor
    logic [7:0]  rsp_lfsr = 8'hC3;
    logic        rsp_stall = 1'b0;
    logic [31:0] hold_rd;
    logic        hold_err;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_stall) begin
                chk("R12 valid held", {31'h0, rsp_valid}, 32'h1);
                chk("R12 rdata held", rsp_rdata, hold_rd);
                chk("R12 err held", {31'h0, rsp_err}, {31'h0, hold_err});
            end
            rsp_lfsr  = {rsp_lfsr[6:0], rsp_lfsr[7] ^ rsp_lfsr[5] ^ rsp_lfsr[4] ^ rsp_lfsr[3]};
            rsp_ready = rsp_lfsr[1] | rsp_lfsr[4];
            if (rsp_valid && rsp_ready) begin
                if (rsp_q.size() == 0) begin
                    chk("R8 unexpected response", rsp_rdata, 32'hFFFF_FFFF);
                end else begin
                    exp_rsp_t r;
                    r = rsp_q.pop_front();
                    chk("R8 rdata", rsp_rdata, r.rdata);
                    chk("R11 err", {31'h0, rsp_err}, {31'h0, r.err});
                end
            end
            rsp_stall = rsp_valid && !rsp_ready;
            hold_rd = rsp_rdata; hold_err = rsp_err;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        print_summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
        chk("R1 bus_valid", {31'h0, bus_valid}, 32'h0);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);

        // fixed examples first
        do_req(32'h0000_1001, 2, 1'b1, 1'b1, 32'hDEAD_BEEF); // R3: be 0110
        do_req(32'h0000_1003, 2, 1'b0, 1'b1, 32'h0);         // R4: 1000 then 0001
        do_req(32'h0000_2002, 4, 1'b1, 1'b0, 32'h1122_3344); // R5
        do_req(32'h0000_2003, 3, 1'b0, 1'b0, 32'h0);         // R11 invalid width

        for (int off = 0; off < 4; off++) begin
            for (int si = 0; si < 3; si++) begin
                for (int m = 0; m < 4; m++) begin
                    int n;
                    n = (si == 0) ? 1 : (si == 1) ? 2 : 4;
                    do_req(32'h1234_5670 + 32'(off) + 32'(16 * m), n, m[0], m[1],
                           32'hA1B2_C3D4 ^ 32'(off * 4 + si));
                end
            end
            do_req(32'h0000_0040 + 32'(off), (off == 0) ? 0 : (off == 1) ? 5 : (off == 2) ? 7 : 6,
                   off[0], off[1], 32'hFFFF_FFFF); // R11
        end

        for (int i = 0; i < 200 && (cyc_q.size() != 0 || rsp_q.size() != 0); i++)
            @(negedge clk);
        chk("R3 no missing bus cycles", 32'(cyc_q.size()), 32'h0);
        chk("R8 no missing responses", 32'(rsp_q.size()), 32'h0);
        print_summary();
        $finish;
    end
endmodule